// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs on the conversion clock and takes one comparator bit from the analog side, which reports on which side of zero the integrator output sits. Each measurement passes through four phases: auto-zero, signal integration, reference integration and integrator zero. For each phase the block drives a one-hot set of analog switch enables. During reference integration it counts clocks in decimal until the comparator reports the zero crossing, and it then latches that count as a 4½-digit BCD reading.

Alongside the reading it produces a busy flag, the input polarity, and registered over-range and under-range flags. A run/hold input chooses between free-running conversions and held results. While held, a short high pulse starts exactly one new measurement.

The phase lengths and the under-range limit are parameters. Their defaults give a 10,001-clock auto-zero, a 10,000-clock signal integration and a reference slot of up to 20,001 clocks. A measurement without over-range therefore lasts 40,002 clocks.

Top module: `dual_slope_seq`

## Requirements
- R1: Phases always run in the order auto-zero, signal integration, reference integration, integrator zero. `sw_en` is one-hot: bit 0 auto-zero, bit 1 input, bit 2 positive reference (polarity 1), bit 3 negative reference (polarity 0), bit 4 integrator zero. While idle (held), bit 0 stays set.
- R2: Auto-zero lasts AZ_LEN clocks and signal integration lasts SI_LEN clocks. In free-running mode without over-range, one measurement spans AZ_LEN+SI_LEN+RI_MAX clocks.
- R3: `busy` is low during auto-zero, rises with the first signal-integration clock, and falls in the cycle after the registered comparator shows the crossing. If the comparator changes during reference clock T (counting from 0), `busy` is high for SI_LEN+T+2 clocks.
- R4: The reading equals T, because the counter is held during the first reference clock. It is presented as DIGITS BCD digits, least significant digit in bits [3:0].
- R5: If no crossing is registered by reference clock RI_MAX-2, reference integration runs its full RI_MAX clocks. `over_range` is then set in the same cycle that `busy` falls, the reading is RI_MAX-1, and the flag clears when the next reference integration starts.
- R6: `under_range` is set when `busy` falls if the crossing-terminated reading is at most UR_LIMIT. It clears when the next signal integration starts.
- R7: `polarity` takes the comparator value at the last signal-integration clock (1 = positive input). It is valid from the first reference clock, stays fixed until the next decision, and is decided even for a zero reading.
- R8: The reading register loads on the first clock after `busy` falls and does not change at any other time.
- R9: Integrator zero fills the rest of the RI_MAX-clock reference slot (RI_MAX-T-2 clocks). After an over-range it lasts IZ_OVR_LEN clocks instead.
- R10: With `run_hold` high, measurements follow one another with no gap. If `run_hold` is low when integrator zero ends, the block idles with `busy` low and the reading unchanged.
- R11: While idle, a high pulse on `run_hold` (at least three clocks wide) starts exactly one measurement. A pulse that ends before the running measurement finishes has no effect.
- R12: During reset `busy`, `over_range` and `under_range` are 0, the reading is 0 and `sw_en` is 5'b00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_hold | input | 1 | Run (high) / hold (low); asynchronous, synchronised inside |
| cmp_in | input | 1 | Comparator: 1 when the integrator is on the positive-input side of zero |
| sw_en | output | 5 | One-hot analog switch enables |
| busy | output | 1 | High through signal and reference integration |
| polarity | output | 1 | Sign of the last measured input, 1 = positive |
| over_range | output | 1 | Last measurement exceeded full scale |
| under_range | output | 1 | Last reading at or below UR_LIMIT |
| result | output | 4*DIGITS | Latched BCD reading |

## Verification
The timing rules below are all counted from the clock in which the bench drives the comparator flip.

| Result | When it is due |
|---|---|
| `busy` falls | Two clocks after the flip: one register for the comparator latch, one for the phase register |
| Both range flags | Same cycle that `busy` falls |
| Reading | One clock after `busy` falls |
| Polarity and the reference switch | First reference clock |

The bench drives stimulus and samples on the falling edge. It locates each phase through `sw_en` and `busy` and counts clocks from there, so every comparison is made in the exact cycle given by these rules. The crossing time is swept over every reference clock, including those that fall into over-range, for both polarities.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_AZ   = 3'd1,
    PH_SI   = 3'd2,
    PH_RI   = 3'd3,
    PH_IZ   = 3'd4
  } phase_e;

  localparam int SW_AZ = 0;
  localparam int SW_IN = 1;
  localparam int SW_RP = 2;
  localparam int SW_RN = 3;
  localparam int SW_IZ = 4;
  localparam int SW_W  = 5;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Binary to packed BCD, eight digits, digit 0 in the low nibble.
  function automatic logic [31:0] bin_to_bcd(input int unsigned v);
    logic [31:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsc_sync2.sv
module dsc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dsc_phase_seq.sv
module dsc_phase_seq
  import dsc_pkg::*;
#(
  parameter int AZ_LEN     = 10001,
  parameter int SI_LEN     = 10000,
  parameter int RI_MAX     = 20001,
  parameter int IZ_OVR_LEN = 6200
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_lvl,
  input  logic   cross_det,
  input  logic   ovr_flag,
  output phase_e phase,
  output logic   ev_az_done,
  output logic   ev_si_done,
  output logic   ev_cross,
  output logic   ev_ovr,
  output logic   ri_first,
  output logic   load_res
);
  localparam int MAXLEN = max_of4(AZ_LEN, SI_LEN, RI_MAX, IZ_OVR_LEN);
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt;
  logic          run_prev;
  logic          ev_start;
  logic          ev_iz_done;

  // Named phase events
  assign ev_start   = (phase == PH_IDLE) && run_lvl && !run_prev;
  assign ev_az_done = (phase == PH_AZ) && (cnt == CW'(AZ_LEN - 1));
  assign ev_si_done = (phase == PH_SI) && (cnt == CW'(SI_LEN - 1));
  assign ri_first   = (phase == PH_RI) && (cnt == '0);
  assign ev_cross   = (phase == PH_RI) && cross_det && (cnt <= CW'(RI_MAX - 2));
  assign ev_ovr     = (phase == PH_RI) && (cnt == CW'(RI_MAX - 1));
  assign ev_iz_done = (phase == PH_IZ) &&
                      (ovr_flag ? (cnt == CW'(IZ_OVR_LEN - 1)) : (cnt == CW'(RI_MAX - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      run_prev <= 1'b0;
      load_res <= 1'b0;
    end else begin
      run_prev <= run_lvl;
      load_res <= ev_cross || ev_ovr;
      unique case (phase)
        PH_IDLE: begin
          if (ev_start) begin
            phase <= PH_AZ;
            cnt   <= '0;
          end
        end
        PH_AZ: begin
          if (ev_az_done) begin
            phase <= PH_SI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SI: begin
          if (ev_si_done) begin
            phase <= PH_RI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RI: begin
          if (ev_cross) begin
            phase <= PH_IZ;
            cnt   <= cnt + 1'b1;   // slot timer keeps running
          end else if (ev_ovr) begin
            phase <= PH_IZ;
            cnt   <= '0;           // extended recovery timed afresh
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_IZ: begin
          if (ev_iz_done) begin
            phase <= run_lvl ? PH_AZ : PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
  parameter int DIGITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  inc,
  output logic [4*DIGITS-1:0]   count
);
  logic [DIGITS-1:0] carry;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] dig;

    if (i == 0) begin : g_c0
      assign carry[i] = inc;
    end else begin : g_cn
      assign carry[i] = carry[i-1] && (count[4*(i-1) +: 4] == 4'd9);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dig <= 4'd0;
      else if (clr)        dig <= 4'd0;
      else if (carry[i])   dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
    end

    assign count[4*i +: 4] = dig;
  end
endmodule

// File: rtl/dsc_result_regs.sv
module dsc_result_regs #(
  parameter int DIGITS   = 5,
  parameter int UR_LIMIT = 1800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_in,
  input  logic                ev_az_done,
  input  logic                ev_si_done,
  input  logic                ev_cross,
  input  logic                ev_ovr,
  input  logic                load_res,
  input  logic [4*DIGITS-1:0] count,
  output logic                zc_q,
  output logic                pol,
  output logic                over,
  output logic                under,
  output logic [4*DIGITS-1:0] result
);
  localparam logic [31:0] UR_FULL = dsc_pkg::bin_to_bcd(UR_LIMIT);

  logic at_or_below;
  // Packed BCD orders the same way as the number it encodes.
  assign at_or_below = (count <= UR_FULL[4*DIGITS-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q   <= 1'b0;
      pol    <= 1'b0;
      over   <= 1'b0;
      under  <= 1'b0;
      result <= '0;
    end else begin
      zc_q <= cmp_in;
      if (ev_si_done) pol <= cmp_in;

      if (ev_si_done)  over <= 1'b0;
      else if (ev_ovr) over <= 1'b1;

      if (ev_az_done)    under <= 1'b0;
      else if (ev_cross) under <= at_or_below;

      if (load_res) result <= count;
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int DIGITS     = 5,
  parameter int AZ_LEN     = 10001,
  parameter int SI_LEN     = 10000,
  parameter int RI_MAX     = 20001,
  parameter int IZ_OVR_LEN = 6200,
  parameter int UR_LIMIT   = 1800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_hold,
  input  logic                cmp_in,
  output logic [SW_W-1:0]     sw_en,
  output logic                busy,
  output logic                polarity,
  output logic                over_range,
  output logic                under_range,
  output logic [4*DIGITS-1:0] result
);
  phase_e              phase;
  logic                run_lvl;
  logic                zc_q;
  logic                cross_det;
  logic                ev_az_done, ev_si_done, ev_cross, ev_ovr, ri_first, load_res;
  logic                cnt_inc;
  logic [4*DIGITS-1:0] count;

  dsc_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (run_hold),
    .q     (run_lvl)
  );

  // Crossing: latched comparator no longer agrees with the decided sign.
  assign cross_det = (zc_q != polarity);

  dsc_phase_seq #(
    .AZ_LEN     (AZ_LEN),
    .SI_LEN     (SI_LEN),
    .RI_MAX     (RI_MAX),
    .IZ_OVR_LEN (IZ_OVR_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_lvl    (run_lvl),
    .cross_det  (cross_det),
    .ovr_flag   (over_range),
    .phase      (phase),
    .ev_az_done (ev_az_done),
    .ev_si_done (ev_si_done),
    .ev_cross   (ev_cross),
    .ev_ovr     (ev_ovr),
    .ri_first   (ri_first),
    .load_res   (load_res)
  );

  // Hold on the first reference clock and on the crossing clock.
  assign cnt_inc = (phase == PH_RI) && !ri_first && !ev_cross;

  dsc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_si_done),
    .inc   (cnt_inc),
    .count (count)
  );

  dsc_result_regs #(.DIGITS(DIGITS), .UR_LIMIT(UR_LIMIT)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_in     (cmp_in),
    .ev_az_done (ev_az_done),
    .ev_si_done (ev_si_done),
    .ev_cross   (ev_cross),
    .ev_ovr     (ev_ovr),
    .load_res   (load_res),
    .count      (count),
    .zc_q       (zc_q),
    .pol        (polarity),
    .over       (over_range),
    .under      (under_range),
    .result     (result)
  );

  always_comb begin
    sw_en = '0;
    busy  = 1'b0;
    unique case (phase)
      PH_SI:   begin sw_en[SW_IN] = 1'b1; busy = 1'b1; end
      PH_RI:   begin
        if (polarity) sw_en[SW_RP] = 1'b1;
        else          sw_en[SW_RN] = 1'b1;
        busy = 1'b1;
      end
      PH_IZ:   sw_en[SW_IZ] = 1'b1;
      default: sw_en[SW_AZ] = 1'b1;
    endcase
  end
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int DIGITS = 5,
  parameter int SI_LEN = 10000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4:0]          sw_en,
  input logic                busy,
  input logic                polarity,
  input logic                over_range,
  input logic                under_range,
  input logic [4*DIGITS-1:0] result
);
  int   si_run;
  logic in_ref;

  assign in_ref = sw_en[2] | sw_en[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        si_run <= 0;
    else if (sw_en[1]) si_run <= si_run + 1;
    else               si_run <= 0;
  end

  assert_sw_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sw_en));

  assert_input_then_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en[1]) |-> in_ref);

  assert_si_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en[1]) |-> (si_run == SI_LEN));

  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sw_en[1]);

  assert_over_with_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_range) |-> $fell(busy));

  assert_over_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ref) |-> !over_range);

  assert_under_with_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(under_range) |-> $fell(busy));

  assert_under_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !under_range);

  assert_polarity_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ref && $past(in_ref)) |-> $stable(polarity));

  assert_result_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> ($past(busy, 2) && !$past(busy)));

endmodule

bind dual_slope_seq dual_slope_seq_chk #(.DIGITS(DIGITS), .SI_LEN(SI_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_en       (sw_en),
  .busy        (busy),
  .polarity    (polarity),
  .over_range  (over_range),
  .under_range (under_range),
  .result      (result)
);

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
  localparam int DIGITS = 5;
  localparam int AZ_LEN = 7;
  localparam int SI_LEN = 10;
  localparam int RI_MAX = 25;
  localparam int IZ_OV  = 6;
  localparam int UR_LIM = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                run_hold = 1'b0;
  logic                cmp_in = 1'b0;
  logic [4:0]          sw_en;
  logic                busy, polarity, over_range, under_range;
  logic [4*DIGITS-1:0] result;

  int checks = 0;
  int fails  = 0;
  int last_reading = 0;

  always #5 clk = ~clk;

  dual_slope_seq #(
    .DIGITS(DIGITS), .AZ_LEN(AZ_LEN), .SI_LEN(SI_LEN),
    .RI_MAX(RI_MAX), .IZ_OVR_LEN(IZ_OV), .UR_LIMIT(UR_LIM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .cmp_in(cmp_in),
    .sw_en(sw_en), .busy(busy), .polarity(polarity),
    .over_range(over_range), .under_range(under_range), .result(result)
  );

  // Decimal digits accumulated by place value.
  function automatic int to_bcd(input int n);
    int acc = 0;
    int place = 1;
    int v = n;
    while (v > 0) begin
      acc = acc + (v % 10) * place;
      place = place * 16;
      v = v / 10;
    end
    return acc;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One measurement. Entered on a falling edge before signal integration.
  task automatic convert(input bit pos, input int t, input bit chk_az, input bit hold);
    int  az = 0;
    int  si = 0;
    int  ri = 0;
    int  iz = 1;
    bit  ovr;
    int  reading;
    cmp_in = pos;
    while (!sw_en[1]) begin az++; @(negedge clk); end
    if (chk_az) chk("R2 auto-zero clocks", az, AZ_LEN);
    chk("R3 busy at signal start", busy, 1);
    if (hold) run_hold = 1'b0;
    while (sw_en[1]) begin si++; @(negedge clk); end
    chk("R2 signal clocks", si, SI_LEN);
    chk("R7 polarity", polarity, pos);
    chk("R1 ref switch", sw_en, pos ? 5'b00100 : 5'b01000);
    chk("R5 over cleared at ref start", over_range, 0);
    while (busy) begin
      if (ri == t) cmp_in = !pos;
      if (hold && ri == 1) run_hold = 1'b1;
      if (hold && ri == 4) run_hold = 1'b0;
      ri++;
      @(negedge clk);
    end
    ovr = (t >= RI_MAX - 2);
    reading = ovr ? RI_MAX - 1 : t;
    chk("R3 reference busy clocks", ri, ovr ? RI_MAX : t + 2);
    chk("R5 over_range", over_range, ovr);
    chk("R6 under_range", under_range, (!ovr && t <= UR_LIM));
    chk("R1 integrator-zero switch", sw_en, 5'b10000);
    chk("R8 reading unchanged as busy falls", result, to_bcd(last_reading));
    @(negedge clk);
    chk("R4 reading", result, to_bcd(reading));
    while (sw_en[4]) begin iz++; @(negedge clk); end
    chk("R9 integrator-zero clocks", iz, ovr ? IZ_OV : RI_MAX - t - 2);
    if (chk_az && !ovr)
      chk("R2 measurement period", az + si + ri + iz, AZ_LEN + SI_LEN + RI_MAX);
    last_reading = reading;
  endtask

  task automatic idle_watch(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || sw_en != 5'b00001 || result != to_bcd(last_reading)) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset over", over_range, 0);
    chk("R12 reset under", under_range, 0);
    chk("R12 reset reading", result, 0);
    chk("R12 reset switches", sw_en, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    run_hold = 1'b1;
    convert(1'b1, 5, 1'b0, 1'b0);
    // R4 R5 R6 R9 sweep: every crossing clock, both signs, free-running (R10)
    for (int p = 0; p < 2; p++) begin
      for (int t = 0; t <= RI_MAX; t++) begin
        convert(p[0], t, 1'b1, 1'b0);
      end
    end
    // R10 hold; the pulse during the measurement must be ignored (R11)
    convert(1'b1, 8, 1'b1, 1'b1);
    idle_watch("R10 held idle", 60);
    // R11 single-shot pulse
    run_hold = 1'b1;
    repeat (3) @(negedge clk);
    run_hold = 1'b0;
    convert(1'b0, 3, 1'b0, 1'b0);
    idle_watch("R11 one measurement per pulse", 60);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule